// File: doc/BRIEF.md
# Split-Phase Set-Associative Read Cache

This block is a 4-way set-associative read cache of 16 KB: 128 sets, 32-byte lines, 32-bit words. A client gives only the 12 untranslated low address bits, the page offset, with a request. The set index and word position sit entirely inside those bits, so the block reads the indexed set straight away and parks the four stored tags, their valid bits and the addressed word of every way in a lookup register. The 20-bit physical frame number arrives later on its own input with its own strobe, after any number of cycles, and only then does the tag compare take place.

On a hit the addressed word is returned. On a miss the block issues one line request to the next memory level, takes eight words back in ascending word order, writes them into a chosen way, marks the line valid under the new tag and then returns the requested word. A request whose two lowest offset bits are not zero is answered at once with an error flag and is never served.

Top module: `vipt_cache`

## Requirements
- R1: After reset `rsp_valid` and `mem_req_valid` are low, `req_ready` is high and every line is invalid, so the first access to any address misses.
- R2: A request with `req_offset[1:0]` not equal to 0 produces `rsp_valid` and `rsp_err` high for one cycle, in the cycle after acceptance, with no memory request and no wait for a frame number.
- R3: The set is selected by `req_offset[11:5]` and the word by `req_offset[4:2]` at acceptance; no response and no memory request appear until `pfn_valid` is seen, however many cycles later; a `pfn_valid` pulse while idle has no effect.
- R4: On a hit, `rsp_valid` is high with `rsp_err` low and `rsp_data` equal to the stored word, in the cycle after the cycle where `pfn_valid` was high.
- R5: On a miss, `mem_req_valid` is high for exactly one cycle, in the cycle after `pfn_valid`, with `mem_req_addr` equal to {pfn, set index, 5'b0}.
- R6: A refill takes eight `mem_rsp_valid` beats, word 0 first, with any idle gaps between beats; `rsp_valid` is high in the cycle after the eighth beat with the requested word, and a later access to that line hits.
- R7: The refilled way is the lowest-numbered invalid way of the set; when all four are valid it is the way named by a per-set pointer that is 0 after reset and advances by one (modulo 4) after every refill into that set.
- R8: `req_ready` is high only when idle; a `req_valid` while `req_ready` is low is ignored and does not alter the response in progress.
- R9: Lines with different frame numbers but the same page offset coexist in one set and each returns its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_offset | input | 12 | Untranslated page-offset bits of the address |
| pfn_valid | input | 1 | Frame number is valid this cycle |
| pfn | input | 20 | Physical frame number for the pending request |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response is a misalignment error |
| rsp_data | output | 32 | Returned word |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_addr | output | 32 | Line-aligned physical address |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_data | input | 32 | Refill beat word |

## Verification
Every result has one fixed cycle: an error answer one cycle after acceptance, a hit one cycle after the frame-number strobe, the line request one cycle after that strobe, and the refill answer one cycle after the eighth beat. The bench drives inputs on the falling edge, steps a behavioural model of the tags, valid bits and replacement pointers, and at every falling edge in between compares the strobes against the model, so an early or late response, a repeated line request or a missing ready is caught in the exact cycle. Frame-number delays, beat gaps and ignored strobes are varied to show the timing holds across them.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int TAG_BITS  = 20;
  localparam int SET_BITS  = 7;
  localparam int NUM_WAYS  = 4;
  localparam int LINE_WRDS = 8;
  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MISS = 2'd2,
    ST_FILL = 2'd3
  } cache_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
  output logic [WAYS-1:0]            rd_vld,
  output logic [WAY_W-1:0]           rd_ptr,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag
);
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld_q   [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags[w] = tag_mem[rd_set][w];
  end
  assign rd_vld = vld_q[rd_set];
  assign rd_ptr = ptr_q[rd_set];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
      ptr_q[wr_set]         <= ptr_q[wr_set] + 1'b1;
    end
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int WPL    = 8,
  parameter int WORD_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WIDX_W = $clog2(WPL),
  localparam int DEPTH  = SETS * WAYS * WPL
) (
  input  logic                        clk,
  input  logic [SET_W-1:0]            rd_set,
  input  logic [WIDX_W-1:0]           rd_word,
  output logic [WAYS-1:0][WORD_W-1:0] rd_words,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WIDX_W-1:0]           wr_word,
  input  logic [WORD_W-1:0]           wr_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    localparam logic [WAY_W-1:0] WAY_ID = WAY_W'(w);
    assign rd_words[w] = mem[{WAY_ID, rd_set, rd_word}];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_way, wr_set, wr_word}] <= wr_data;
  end
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    way = ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int TAG_W  = TAG_BITS,
  parameter int SET_W  = SET_BITS,
  parameter int WAYS   = NUM_WAYS,
  parameter int WPL    = LINE_WRDS,
  parameter int WORD_W = WORD_BITS,
  localparam int SETS   = 1 << SET_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WIDX_W = $clog2(WPL),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = WIDX_W + BYTE_W,
  localparam int PAGE_W = SET_W + OFF_W,
  localparam int ADDR_W = TAG_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_offset,
  input  logic              pfn_valid,
  input  logic [TAG_W-1:0]  pfn,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  cache_state_e state_q, state_d;

  logic [SET_W-1:0]            set_q, set_d;
  logic [WIDX_W-1:0]           word_q, word_d;
  logic [WAYS-1:0][TAG_W-1:0]  ltag_q, ltag_d;
  logic [WAYS-1:0]             lvld_q, lvld_d;
  logic [WAYS-1:0][WORD_W-1:0] lword_q, lword_d;
  logic [WAY_W-1:0]            victim_q, victim_d;
  logic [TAG_W-1:0]            pfn_q, pfn_d;
  logic [WIDX_W-1:0]           beat_q, beat_d;
  logic [WORD_W-1:0]           fword_q, fword_d;
  logic                        rsp_valid_q, rsp_valid_d;
  logic                        rsp_err_q, rsp_err_d;
  logic [WORD_W-1:0]           rsp_data_q, rsp_data_d;
  logic                        mreq_q, mreq_d;

  // array read side
  logic [SET_W-1:0]            rd_set;
  logic [WIDX_W-1:0]           rd_word;
  logic [WAYS-1:0][TAG_W-1:0]  arr_tags;
  logic [WAYS-1:0]             arr_vld;
  logic [WAY_W-1:0]            arr_ptr;
  logic [WAYS-1:0][WORD_W-1:0] arr_words;
  logic [WAY_W-1:0]            pick_way;

  // compare
  logic [WAYS-1:0]   hit_vec;
  logic [WORD_W-1:0] hit_word;
  logic              misaligned;
  logic              fill_we, last_beat;

  assign misaligned = |req_offset[BYTE_W-1:0];
  assign rd_set  = (state_q == ST_IDLE) ? req_offset[PAGE_W-1:OFF_W] : set_q;
  assign rd_word = (state_q == ST_IDLE) ? req_offset[OFF_W-1:BYTE_W] : word_q;

  vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (rd_set),
    .rd_tags (arr_tags),
    .rd_vld  (arr_vld),
    .rd_ptr  (arr_ptr),
    .wr_en   (fill_we && last_beat),
    .wr_set  (set_q),
    .wr_way  (victim_q),
    .wr_tag  (pfn_q)
  );

  vipt_data_store #(.SETS(SETS), .WAYS(WAYS), .WPL(WPL), .WORD_W(WORD_W)) data_i (
    .clk      (clk),
    .rd_set   (rd_set),
    .rd_word  (rd_word),
    .rd_words (arr_words),
    .wr_en    (fill_we),
    .wr_way   (victim_q),
    .wr_set   (set_q),
    .wr_word  (beat_q),
    .wr_data  (mem_rsp_data)
  );

  vipt_victim_sel #(.WAYS(WAYS)) victim_i (
    .vld (lvld_q),
    .ptr (arr_ptr),
    .way (pick_way)
  );

  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = lvld_q[w] && (ltag_q[w] == pfn);
      if (hit_vec[w]) hit_word = hit_word | lword_q[w];
    end
  end

  assign fill_we   = (state_q == ST_FILL) && mem_rsp_valid;
  assign last_beat = (beat_q == WIDX_W'(WPL - 1));

  // next-state logic
  always_comb begin
    state_d     = state_q;
    set_d       = set_q;
    word_d      = word_q;
    ltag_d      = ltag_q;
    lvld_d      = lvld_q;
    lword_d     = lword_q;
    victim_d    = victim_q;
    pfn_d       = pfn_q;
    beat_d      = beat_q;
    fword_d     = fword_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = rsp_data_q;
    mreq_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misaligned) begin
            rsp_valid_d = 1'b1;
            rsp_err_d   = 1'b1;
            rsp_data_d  = '0;
          end else begin
            set_d   = rd_set;
            word_d  = rd_word;
            ltag_d  = arr_tags;
            lvld_d  = arr_vld;
            lword_d = arr_words;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (pfn_valid) begin
          if (|hit_vec) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = hit_word;
            state_d     = ST_IDLE;
          end else begin
            pfn_d    = pfn;
            victim_d = pick_way;
            mreq_d   = 1'b1;
            beat_d   = '0;
            state_d  = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        state_d = ST_FILL;
      end
      ST_FILL: begin
        if (fill_we) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == word_q) fword_d = mem_rsp_data;
          if (last_beat) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = (beat_q == word_q) ? mem_rsp_data : fword_q;
            state_d     = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      mreq_q      <= 1'b0;
      beat_q      <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      mreq_q      <= mreq_d;
      beat_q      <= beat_d;
    end
  end

  // datapath registers, loaded only under their enables
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid) begin
      set_q   <= set_d;
      word_q  <= word_d;
      ltag_q  <= ltag_d;
      lvld_q  <= lvld_d;
      lword_q <= lword_d;
    end
    if (state_q == ST_WAIT && pfn_valid) begin
      pfn_q    <= pfn_d;
      victim_q <= victim_d;
    end
    if (fill_we) fword_q <= fword_d;
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = rsp_valid_q;
  assign rsp_err       = rsp_err_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = {pfn_q, set_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              pfn_valid,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  // R2
  err_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R2
  err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_ready));

  // R5
  line_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R5
  line_req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R5
  line_req_after_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $past(pfn_valid));

  // R4
  data_rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(pfn_valid || mem_rsp_valid));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R6
  no_rsp_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && rsp_valid));
endmodule

bind vipt_cache vipt_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .pfn_valid     (pfn_valid),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/vipt_cache_tb_top.sv
module vipt_cache_tb_top;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [11:0] req_offset;
  logic        pfn_valid;
  logic [19:0] pfn;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #(CLK_P / 2) clk = ~clk;

  vipt_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_offset(req_offset),
    .pfn_valid(pfn_valid), .pfn(pfn),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model state
  bit          m_vld [128][4];
  logic [19:0] m_tag [128][4];
  int          m_ptr [128];

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_pfn_poke();
    pfn_valid = 1'b1; pfn = 20'hBEEF0;
    @(negedge clk);
    pfn_valid = 1'b0;
    check("R3 idle pfn rsp", 32'(rsp_valid), 0);
    check("R3 idle pfn mem", 32'(mem_req_valid), 0);
    check("R3 idle ready", 32'(req_ready), 1);
  endtask

  // one read transaction; called and returns on a falling edge
  task automatic do_read(logic [11:0] off, logic [19:0] fn, int dly, bit poke, bit gaps);
    int          set  = int'(off[11:5]);
    logic [31:0] addr = {fn, off};
    int          hw   = -1;
    check("R8 ready idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    if (off[1:0] != 2'b00) begin
      check("R2 err rsp_valid", 32'(rsp_valid), 1);
      check("R2 err flag", 32'(rsp_err), 1);
      check("R2 no mem req", 32'(mem_req_valid), 0);
      return;
    end
    check("R3 no early rsp", 32'(rsp_valid), 0);
    check("R8 busy", 32'(req_ready), 0);
    for (int d = 0; d < dly; d++) begin
      if (poke) begin req_valid = 1'b1; req_offset = off ^ 12'h0A4; end
      @(negedge clk);
      req_valid = 1'b0;
      check("R3 wait rsp", 32'(rsp_valid), 0);
      check("R3 wait mem", 32'(mem_req_valid), 0);
      check("R8 wait ready", 32'(req_ready), 0);
    end
    pfn_valid = 1'b1; pfn = fn;
    @(negedge clk);
    pfn_valid = 1'b0;
    for (int w = 0; w < 4; w++) if (m_vld[set][w] && m_tag[set][w] == fn) hw = w;
    if (hw >= 0) begin
      check("R4 hit valid", 32'(rsp_valid), 1);
      check("R4 hit err", 32'(rsp_err), 0);
      check("R4 R9 hit data", rsp_data, mem_word(addr));
      check("R5 no req on hit", 32'(mem_req_valid), 0);
      return;
    end
    check("R5 req valid", 32'(mem_req_valid), 1);
    check("R5 req addr", mem_req_addr, {fn, off[11:5], 5'b0});
    check("R5 no rsp", 32'(rsp_valid), 0);
    @(negedge clk);
    check("R5 single pulse", 32'(mem_req_valid), 0);
    for (int b = 0; b < 8; b++) begin
      if (gaps && (b % 3 == 1)) begin
        @(negedge clk);
        check("R6 gap rsp", 32'(rsp_valid), 0);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word({fn, off[11:5], 3'(b), 2'b00});
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check("R6 rsp timing", 32'(rsp_valid), (b == 7) ? 1 : 0);
    end
    check("R6 refill data", rsp_data, mem_word(addr));
    check("R6 refill err", 32'(rsp_err), 0);
    begin
      int v = -1;
      for (int w = 3; w >= 0; w--) if (!m_vld[set][w]) v = w;
      if (v < 0) v = m_ptr[set];
      m_vld[set][v] = 1'b1;
      m_tag[set][v] = fn;
      m_ptr[set]    = (m_ptr[set] + 1) % 4;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 128; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_offset = '0; pfn_valid = 1'b0;
    pfn = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);

    do_read(12'h3D4, 20'h0000D, 0, 1'b0, 1'b0); // R1 cold miss
    do_read(12'h3D4, 20'h0000D, 3, 1'b0, 1'b0); // R3 R4 late pfn hit
    do_read(12'h3C0, 20'h0000D, 1, 1'b0, 1'b0); // word 0
    do_read(12'h3DC, 20'h0000D, 0, 1'b0, 1'b0); // word 7
    do_read(12'h3D5, 20'h0000D, 0, 1'b0, 1'b0); // R2
    do_read(12'h3D6, 20'h0000D, 0, 1'b0, 1'b0); // R2
    idle_pfn_poke();
    do_read(12'h3D4, 20'h12345, 2, 1'b1, 1'b1); // R9 same offset, R8 poke
    do_read(12'h3D4, 20'h0000D, 0, 1'b0, 1'b0); // R9 old line kept
    do_read(12'h3D4, 20'h12345, 0, 1'b0, 1'b0);
    do_read(12'h01C, 20'h00AAA, 0, 1'b0, 1'b1); // requested word is last beat
    // R7 replacement in set 0x21
    for (int i = 0; i < 5; i++) do_read({7'h21, 5'h08}, 20'h40000 + 20'(i), 0, 1'b0, 1'b0);
    do_read({7'h21, 5'h08}, 20'h40001, 0, 1'b0, 1'b0); // still resident
    do_read({7'h21, 5'h08}, 20'h40000, 0, 1'b0, 1'b0); // evicted: misses
    do_read({7'h21, 5'h08}, 20'h40001, 0, 1'b0, 1'b0); // now evicted by pointer
    do_read({7'h21, 5'h10}, 20'h40004, 1, 1'b0, 1'b0);
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic [11:0] o;
      o = {3'b010, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)), 2'b00};
      if ($urandom_range(0, 9) == 0) o[1:0] = 2'($urandom_range(1, 3));
      do_read(o, 20'h70000 + 20'($urandom_range(0, 5)), $urandom_range(0, 4),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if (i % 50 == 0) idle_pfn_poke();
    end
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule